// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a down-counting timer on a simple 32-bit register bus. Software writes a reload value, picks a clock divider and turns counting on. In plain timer mode, each time the count runs out the block raises an event flag and starts again from the reload value. In watchdog mode, running out of count produces a one-cycle system reset pulse and a sticky reset flag. Software keeps the watchdog from firing by writing a new reload value.

Two rules protect watchdog mode from software that has gone astray. First, only a reload write whose value differs from the value currently held restarts the count, so a loop that keeps writing the same word does not service the watchdog. Second, watchdog mode cannot be turned off until two fixed key words have been written, in order, to the disarm register. The next control write after that may clear the mode.

Register word offsets on `addr`: 0 reload, 1 count (read-only), 2 control, 3 disarm (write-only, reads zero), 4 status. Reads are combinational from `addr`. Writes take effect on the clock edge where `wrEn` is high.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the reload, count, control and status registers read zero and `wdResetPulse` is low.
- R2: In the control register, bit 0 is the run enable, bit 3 is watchdog mode and bits 15:8 are the divider field. All other bits read as zero whatever was written.
- R3: A reload write (offset 0) whose value differs from the stored reload value stores it and copies it into the count on the same edge. A write of the stored value changes neither register.
- R4: While run enable is set, the count drops by one every (divider field + 1) clock cycles. While run enable is clear, the count holds.
- R5: In watchdog mode, a divider tick that finds the count at zero drives `wdResetPulse` high for the following cycle, sets status bit 0, and reloads the count from the reload register.
- R6: With watchdog mode clear, a divider tick that finds the count at zero sets status bit 1 and reloads the count, with no reset pulse.
- R7: Writing 1 to a status bit clears that bit. Writing 0 leaves it unchanged.
- R8: While watchdog mode is set and the unlock sequence has not completed, a control write with bit 3 at zero is ignored as a whole.
- R9: Writing 0x12345678 and then 0x87654321 to the disarm register (offset 3) completes the unlock. A following control write of zero then stops counting and clears watchdog mode. Any control write uses up the unlock.
- R10: A disarm write that is not the next expected key word sends the unlock sequence back to its start.
- R11: Writes to the count register (offset 1) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counting clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register word offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the register at `addr` |
| wdResetPulse | output | 1 | One-cycle system reset request |

## Verification
If the divider or count state is wrong, the count register shows it within one divide period, because the readable count moves off the expected sequence. If the unlock machine is stuck in the wrong state, the first control write after the key words gives it away: the control register either keeps watchdog mode when it should not, or drops it when it should not. A wrong expiry path shows up one cycle after the count reaches zero, as a missing or extra reset pulse, or as the wrong status bit being set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PRE_W = 8;
  localparam logic [31:0] UNLOCK_KEY_A = 32'h1234_5678;
  localparam logic [31:0] UNLOCK_KEY_B = 32'h8765_4321;

  typedef enum logic [1:0] {LK_IDLE, LK_HALF, LK_OPEN} lockState_e;

  typedef enum logic [2:0] {
    REG_LOAD   = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_DISARM = 3'd3,
    REG_STATUS = 3'd4
  } regIdx_e;

  typedef struct packed {
    logic             reload;
    logic             countEn;
    logic [PRE_W-1:0] divide;
  } dpStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] counterVal,
  output logic              expire
);
  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic             atZero;

  assign tick   = strobe.countEn && (preCnt >= strobe.divide);
  assign atZero = (counterVal == '0);
  assign expire = tick && atZero && !strobe.reload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt     <= '0;
      counterVal <= '0;
    end else if (strobe.reload) begin
      preCnt     <= '0;
      counterVal <= wrData;
    end else if (strobe.countEn) begin
      if (tick) begin
        preCnt     <= '0;
        counterVal <= atZero ? loadVal : counterVal - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              resetFlag,
  output logic              eventFlag,
  output logic              wdMode,
  output logic              unlocked,
  output logic              wdResetPulse
);
  localparam int MODE_BIT = 3;
  localparam int DIV_LSB  = 8;

  logic             enableBit;
  logic [PRE_W-1:0] divideReg;
  lockState_e       lockState;

  logic wrLoad, wrCtrl, wrDisarm, wrStatus;
  logic loadChanged, ctrlBlocked;

  assign wrLoad   = wrEn && (addr == ADDR_W'(REG_LOAD));
  assign wrCtrl   = wrEn && (addr == ADDR_W'(REG_CTRL));
  assign wrDisarm = wrEn && (addr == ADDR_W'(REG_DISARM));
  assign wrStatus = wrEn && (addr == ADDR_W'(REG_STATUS));

  assign loadChanged = wrLoad && (wrData != loadVal);
  assign unlocked    = (lockState == LK_OPEN);
  assign ctrlBlocked = wdMode && !unlocked && !wrData[MODE_BIT];

  assign strobe.reload  = loadChanged;
  assign strobe.countEn = enableBit;
  assign strobe.divide  = divideReg;

  always_comb begin
    ctrlWord = '0;
    ctrlWord[0] = enableBit;
    ctrlWord[MODE_BIT] = wdMode;
    ctrlWord[DIV_LSB +: PRE_W] = divideReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal <= '0;
    end else if (loadChanged) begin
      loadVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableBit <= 1'b0;
      wdMode    <= 1'b0;
      divideReg <= '0;
    end else if (wrCtrl && !ctrlBlocked) begin
      enableBit <= wrData[0];
      wdMode    <= wrData[MODE_BIT];
      divideReg <= wrData[DIV_LSB +: PRE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockState <= LK_IDLE;
    end else if (wrCtrl) begin
      lockState <= LK_IDLE;
    end else if (wrDisarm) begin
      if (lockState == LK_HALF && wrData == DATA_W'(UNLOCK_KEY_B)) begin
        lockState <= LK_OPEN;
      end else if (wrData == DATA_W'(UNLOCK_KEY_A)) begin
        lockState <= LK_HALF;
      end else begin
        lockState <= LK_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetFlag    <= 1'b0;
      eventFlag    <= 1'b0;
      wdResetPulse <= 1'b0;
    end else begin
      resetFlag    <= (resetFlag && !(wrStatus && wrData[0])) || (expire && wdMode);
      eventFlag    <= (eventFlag && !(wrStatus && wrData[1])) || (expire && !wdMode);
      wdResetPulse <= expire && wdMode;
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              wdResetPulse
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] counterVal;
  logic [DATA_W-1:0] ctrlWord;
  logic              expire;
  logic              resetFlag;
  logic              eventFlag;
  logic              wdMode;
  logic              unlocked;
  logic              countEn;

  assign countEn = strobe.countEn;

  wdt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .addr         (addr),
    .wrData       (wrData),
    .expire       (expire),
    .strobe       (strobe),
    .loadVal      (loadVal),
    .ctrlWord     (ctrlWord),
    .resetFlag    (resetFlag),
    .eventFlag    (eventFlag),
    .wdMode       (wdMode),
    .unlocked     (unlocked),
    .wdResetPulse (wdResetPulse)
  );

  wdt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .loadVal    (loadVal),
    .counterVal (counterVal),
    .expire     (expire)
  );

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(REG_LOAD):   rdData = loadVal;
      ADDR_W'(REG_COUNT):  rdData = counterVal;
      ADDR_W'(REG_CTRL):   rdData = ctrlWord;
      ADDR_W'(REG_STATUS): rdData = {{(DATA_W-2){1'b0}}, eventFlag, resetFlag};
      default:             rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              wdResetPulse,
  input logic              wdMode,
  input logic              unlocked,
  input logic [DATA_W-1:0] loadVal,
  input logic [DATA_W-1:0] counterVal,
  input logic              resetFlag,
  input logic              countEn
);
  logic loadWr;
  assign loadWr = wrEn && (addr == ADDR_W'(REG_LOAD));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadWr && wrData != loadVal) |=> (counterVal == $past(wrData) && loadVal == $past(wrData)));

  // R3
  same_load_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadWr && wrData == loadVal) |=> $stable(loadVal));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !loadWr) |=> $stable(counterVal));

  // R5
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdResetPulse |-> resetFlag);

  // R6
  pulse_needs_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdResetPulse |-> $past(wdMode));

  // R8
  locked_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdMode && !unlocked && wrEn && addr == ADDR_W'(REG_CTRL) && !wrData[3]) |=> wdMode);
endmodule

bind wdt_timer wdt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .addr         (addr),
  .wrData       (wrData),
  .wdResetPulse (wdResetPulse),
  .wdMode       (wdMode),
  .unlocked     (unlocked),
  .loadVal      (loadVal),
  .counterVal   (counterVal),
  .resetFlag    (resetFlag),
  .countEn      (countEn)
);

// File: tb/test_wdt_timer.sv
module test_wdt_timer;
  logic        clk;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        wdResetPulse;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] A_LOAD = 3'd0, A_COUNT = 3'd1, A_CTRL = 3'd2,
                         A_DIS = 3'd3, A_STAT = 3'd4;

  wdt_timer i_wdt_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .wdResetPulse(wdResetPulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic doWrite(input logic [2:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic expectReg(input logic [2:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    readReg(a, v);
    check(v === e, req, v, e);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    expectReg(A_LOAD, 32'h0, "R1 load");
    expectReg(A_COUNT, 32'h0, "R1 count");
    expectReg(A_CTRL, 32'h0, "R1 control");
    expectReg(A_STAT, 32'h0, "R1 status");
    check(wdResetPulse === 1'b0, "R1 pulse", {31'b0, wdResetPulse}, 32'h0);
  endtask

  task automatic testControlFields();
    doWrite(A_CTRL, 32'hFFFF_AB00);
    expectReg(A_CTRL, 32'h0000_AB00, "R2 masked fields");
    doWrite(A_CTRL, 32'h0);
  endtask

  task automatic testCounting();
    doWrite(A_CTRL, 32'h0000_0201);
    expectReg(A_CTRL, 32'h0000_0201, "R2 enable readback");
    doWrite(A_LOAD, 32'd100);
    expectReg(A_COUNT, 32'd100, "R3 reload copied");
    waitCycles(3);
    expectReg(A_COUNT, 32'd99, "R4 divide by 3 first step");
    waitCycles(3);
    expectReg(A_COUNT, 32'd98, "R4 divide by 3 second step");
    doWrite(A_CTRL, 32'h0000_0200);
    waitCycles(10);
    expectReg(A_COUNT, 32'd98, "R4 hold when disabled");
  endtask

  task automatic testServiceRule();
    doWrite(A_LOAD, 32'd100);
    expectReg(A_COUNT, 32'd98, "R3 identical reload ignored");
    doWrite(A_LOAD, 32'd50);
    expectReg(A_COUNT, 32'd50, "R3 new reload value");
    expectReg(A_LOAD, 32'd50, "R3 reload register");
    doWrite(A_COUNT, 32'h1234);
    expectReg(A_COUNT, 32'd50, "R11 count write ignored");
  endtask

  task automatic testTimerExpiry();
    doWrite(A_CTRL, 32'h0000_0001);
    doWrite(A_LOAD, 32'd3);
    waitCycles(3);
    expectReg(A_COUNT, 32'd0, "R6 count at zero");
    expectReg(A_STAT, 32'h0, "R6 no flag before expiry");
    waitCycles(1);
    expectReg(A_STAT, 32'h2, "R6 event flag");
    expectReg(A_COUNT, 32'd3, "R6 reloaded");
    check(wdResetPulse === 1'b0, "R6 no reset pulse", {31'b0, wdResetPulse}, 32'h0);
    doWrite(A_STAT, 32'h2);
    expectReg(A_STAT, 32'h0, "R7 event flag cleared");
    doWrite(A_CTRL, 32'h0);
  endtask

  task automatic testWatchdogExpiry();
    doWrite(A_CTRL, 32'h0000_0009);
    doWrite(A_LOAD, 32'd4);
    waitCycles(4);
    expectReg(A_COUNT, 32'd0, "R5 count at zero");
    check(wdResetPulse === 1'b0, "R5 no early pulse", {31'b0, wdResetPulse}, 32'h0);
    waitCycles(1);
    check(wdResetPulse === 1'b1, "R5 pulse high", {31'b0, wdResetPulse}, 32'h1);
    expectReg(A_STAT, 32'h1, "R5 reset flag");
    expectReg(A_COUNT, 32'd4, "R5 reloaded");
    waitCycles(1);
    check(wdResetPulse === 1'b0, "R5 pulse one cycle", {31'b0, wdResetPulse}, 32'h0);
  endtask

  task automatic testLocking();
    doWrite(A_CTRL, 32'h0000_0F00);
    expectReg(A_CTRL, 32'h0000_0009, "R8 locked control write ignored");
    doWrite(A_DIS, 32'h1234_5678);
    doWrite(A_DIS, 32'hDEAD_BEEF);
    doWrite(A_DIS, 32'h8765_4321);
    doWrite(A_CTRL, 32'h0);
    expectReg(A_CTRL, 32'h0000_0009, "R10 wrong word restarts sequence");
    doWrite(A_DIS, 32'h8765_4321);
    doWrite(A_CTRL, 32'h0);
    expectReg(A_CTRL, 32'h0000_0009, "R10 second key alone");
  endtask

  task automatic testUnlock();
    logic [31:0] c0;
    doWrite(A_DIS, 32'h1234_5678);
    doWrite(A_DIS, 32'h8765_4321);
    doWrite(A_CTRL, 32'h0);
    expectReg(A_CTRL, 32'h0, "R9 mode cleared after unlock");
    readReg(A_COUNT, c0);
    waitCycles(5);
    expectReg(A_COUNT, c0, "R9 counting stopped");
    check(wdResetPulse === 1'b0, "R9 no pulse after stop", {31'b0, wdResetPulse}, 32'h0);
    doWrite(A_STAT, 32'h1);
    expectReg(A_STAT, 32'h0, "R7 reset flag cleared");
    doWrite(A_CTRL, 32'h0000_0009);
    doWrite(A_CTRL, 32'h0);
    expectReg(A_CTRL, 32'h0000_0009, "R9 unlock used up");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    testReset();
    testControlFields();
    testCounting();
    testServiceRule();
    testTimerExpiry();
    testWatchdogExpiry();
    testLocking();
    testUnlock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule